// File: doc/BRIEF.md
# OTP Packet Directory Scanner

This block walks a packet-organised one-time-programmable array after reset and builds a directory of it. Each packet in the array starts with a one-word header whose length field gives the number of payload words that follow. The scanner reads headers one at a time through a simple read-only memory port. It records the start word offset of every packet under a dense, sequential packet ID, and it adds up the bytes the packets occupy. The payload words are never read. The scanner jumps from each header straight to the next one.

The directory is read through a combinational lookup port. Software or another block presents a packet ID and gets back that packet's start offset together with a valid flag. The packet count, the byte total, a done flag and an overflow flag are exported as plain outputs. A one-cycle start pulse discards the directory and walks the array again from word zero.

Top module: `otp_dir_scanner`

## Requirements
- R1: After reset is released, and after every start pulse, the walk begins on its own at word offset 0, and packets receive IDs 0, 1, 2 and so on in the order their headers are found.
- R2: A header read is a one-cycle `rom_rd` pulse with the word offset on `rom_addr`. The word is taken from `rom_data` in the following cycle, and at most one read is outstanding.
- R3: The payload length S of a header is header bits 15:8. All other header bits are ignored.
- R4: A header with S = 0 ends the walk. It is not recorded, and `done` rises.
- R5: After a packet with length S at offset P is recorded, the next header is read at P + S + 2.
- R6: Each recorded packet adds 4*(S+1) to `total_bytes`.
- R7: Once `total_bytes` is 11264 or more, the walk ends without reading another header.
- R8: The directory holds 64 packets. If a header with S != 0 is read while 64 are already recorded, `overflow` and `done` rise and the count stays at 64. Exactly 64 packets followed by an S = 0 header leave `overflow` at 0.
- R9: While `done` is 1 and `lk_id` is below `pkt_count`, `lk_valid` is 1 in the same cycle and `lk_offset` is that packet's start offset. Otherwise `lk_valid` is 0 and `lk_offset` is 0.
- R10: While the walk is in progress (`done` = 0), every lookup returns invalid.
- R11: A start pulse, even in the middle of a walk, clears the count, the total, `done` and `overflow` at the next edge, and then restarts the walk as in R1.
- R12: Reset is synchronous and active low. It clears `pkt_count`, `total_bytes`, `done` and `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse: discard the directory and walk again |
| rom_rd | output | 1 | Header read strobe |
| rom_addr | output | 16 | Word offset of the header being read |
| rom_data | input | 32 | Header word, valid the cycle after `rom_rd` |
| lk_id | input | 6 | Packet ID to look up |
| lk_valid | output | 1 | The lookup hit a recorded packet |
| lk_offset | output | 16 | Start word offset of the looked-up packet |
| pkt_count | output | 7 | Number of packets recorded |
| total_bytes | output | 16 | Bytes occupied by the recorded packets |
| done | output | 1 | The walk has ended |
| overflow | output | 1 | A packet was found beyond the directory's capacity |

## Verification
Every cycle, the assertions check the lookup gating, the read protocol and the size limit. The lookup gating covers no hit while busy, no hit for an ID at or beyond the count, and a zero offset on a miss. The read protocol covers single outstanding reads and a first read at word zero. The assertions also check the clearing effect of start, the steady state once the walk ends, and the link between overflow and a full directory. The offsets themselves, the S+2 stride, the byte totals, where the walk stops on a zero header or at the byte limit, and a restart in mid-walk onto new array contents can only be shown by the bench. It does this by filling its memory model with known packet layouts and comparing the directory against values computed from the layout.

// File: rtl/otp_dir_pkg.sv
// Shared constants and types for the OTP packet directory scanner.
// Assumes a 32-bit header word with the payload length in one byte field.
package otp_dir_pkg;

    localparam int HDR_W       = 32;
    localparam int LEN_LSB     = 8;
    localparam int LEN_W       = 8;

    typedef enum logic [1:0] {
        ST_READ = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } walk_state_t;

    // Extract the payload length field from a header word.
    function automatic logic [LEN_W-1:0] hdr_len(input logic [HDR_W-1:0] w);
        return w[LEN_LSB +: LEN_W];
    endfunction

endpackage

// File: rtl/otp_dir_walker.sv
// Header walker: issues one header read at a time, decodes the length,
// advances the word offset and the byte total, and produces table writes.
// Assumes a read port with exactly one cycle of latency.
module otp_dir_walker
    import otp_dir_pkg::*;
#(
    parameter int MAX_PKT    = 64,
    parameter int AW         = 16,
    parameter int SW         = 16,
    parameter int SIZE_LIMIT = 11264,
    localparam int IDW       = $clog2(MAX_PKT),
    localparam int CW        = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len_in,
    output logic             rd_req,
    output logic [AW-1:0]    rd_addr,
    output logic             rec_we,
    output logic [IDW-1:0]   rec_idx,
    output logic [AW-1:0]    rec_off,
    output logic [CW-1:0]    count,
    output logic [SW-1:0]    total,
    output logic             walk_done,
    output logic             walk_ovf
);

    walk_state_t   state;
    logic [AW-1:0] cur_off;
    logic          limit_hit;
    logic          full;
    logic          len_zero;
    logic [SW-1:0] pkt_bytes;

    // Decode the walk conditions from current state and header length.
    always_comb begin
        limit_hit = (total >= SW'(SIZE_LIMIT));
        full      = (count == CW'(MAX_PKT));
        len_zero  = (len_in == '0);
        pkt_bytes = (SW'(len_in) + SW'(1)) << 2;
    end

    // Drive the read port and the table write from the state.
    always_comb begin
        rd_req    = (state == ST_READ) && !limit_hit;
        rd_addr   = cur_off;
        rec_we    = (state == ST_WAIT) && !len_zero && !full && !start;
        rec_idx   = IDW'(count);
        rec_off   = cur_off;
        walk_done = (state == ST_DONE);
    end

    // Walk sequencer with offset, count, total and overflow registers.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            state    <= ST_READ;
            cur_off  <= '0;
            count    <= '0;
            total    <= '0;
            walk_ovf <= 1'b0;
        end else begin
            case (state)
                ST_READ: begin
                    state <= limit_hit ? ST_DONE : ST_WAIT;
                end
                ST_WAIT: begin
                    if (len_zero) begin
                        state <= ST_DONE;
                    end else if (full) begin
                        walk_ovf <= 1'b1;
                        state    <= ST_DONE;
                    end else begin
                        count   <= count + CW'(1);
                        total   <= total + pkt_bytes;
                        cur_off <= cur_off + AW'(len_in) + AW'(2);
                        state   <= ST_READ;
                    end
                end
                default: begin
                    state <= ST_DONE;
                end
            endcase
        end
    end

endmodule

// File: rtl/otp_dir_table.sv
// Packet directory storage and lookup: one offset register per packet ID,
// written by the walker, read combinationally by ID once the walk is done.
// Assumes entries at or above the count are stale and must not be returned.
module otp_dir_table #(
    parameter int MAX_PKT = 64,
    parameter int AW      = 16,
    localparam int IDW    = $clog2(MAX_PKT),
    localparam int CW     = $clog2(MAX_PKT + 1)
) (
    input  logic           clk,
    input  logic           rec_we,
    input  logic [IDW-1:0] rec_idx,
    input  logic [AW-1:0]  rec_off,
    input  logic           walk_done,
    input  logic [CW-1:0]  count,
    input  logic [IDW-1:0] lk_id,
    output logic           lk_valid,
    output logic [AW-1:0]  lk_offset
);

    logic [MAX_PKT*AW-1:0] flat;

    for (genvar i = 0; i < MAX_PKT; i++) begin : g_entry
        logic [AW-1:0] q;
        // Capture the packet start offset when this entry is addressed.
        always_ff @(posedge clk) begin
            if (rec_we && (rec_idx == IDW'(i))) begin
                q <= rec_off;
            end
        end
        assign flat[i*AW +: AW] = q;
    end

    // Gate the lookup with completion and the recorded count.
    always_comb begin
        lk_valid  = walk_done && (CW'(lk_id) < count);
        lk_offset = lk_valid ? flat[lk_id*AW +: AW] : '0;
    end

endmodule

// File: rtl/otp_dir_scanner.sv
// Top of the OTP packet directory scanner: joins the header walker to the
// directory table and exposes the read port, lookup port and status.
// Assumes the attached memory returns a header word one cycle after a read.
module otp_dir_scanner
    import otp_dir_pkg::*;
#(
    parameter int MAX_PKT    = 64,
    parameter int AW         = 16,
    parameter int SW         = 16,
    parameter int SIZE_LIMIT = 11264,
    localparam int IDW       = $clog2(MAX_PKT),
    localparam int CW        = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             rom_rd,
    output logic [AW-1:0]    rom_addr,
    input  logic [HDR_W-1:0] rom_data,
    input  logic [IDW-1:0]   lk_id,
    output logic             lk_valid,
    output logic [AW-1:0]    lk_offset,
    output logic [CW-1:0]    pkt_count,
    output logic [SW-1:0]    total_bytes,
    output logic             done,
    output logic             overflow
);

    logic             rec_we;
    logic [IDW-1:0]   rec_idx;
    logic [AW-1:0]    rec_off;
    logic [LEN_W-1:0] hdr_length;
    logic             unused_hdr_bits;

    // Pick the length field out of the header word; the rest is ignored.
    always_comb begin
        hdr_length      = hdr_len(rom_data);
        unused_hdr_bits = ^{rom_data[HDR_W-1:LEN_LSB+LEN_W], rom_data[LEN_LSB-1:0]};
    end

    otp_dir_walker #(
        .MAX_PKT(MAX_PKT), .AW(AW), .SW(SW), .SIZE_LIMIT(SIZE_LIMIT)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .len_in    (hdr_length),
        .rd_req    (rom_rd),
        .rd_addr   (rom_addr),
        .rec_we    (rec_we),
        .rec_idx   (rec_idx),
        .rec_off   (rec_off),
        .count     (pkt_count),
        .total     (total_bytes),
        .walk_done (done),
        .walk_ovf  (overflow)
    );

    otp_dir_table #(
        .MAX_PKT(MAX_PKT), .AW(AW)
    ) u_table (
        .clk       (clk),
        .rec_we    (rec_we),
        .rec_idx   (rec_idx),
        .rec_off   (rec_off),
        .walk_done (done),
        .count     (pkt_count),
        .lk_id     (lk_id),
        .lk_valid  (lk_valid),
        .lk_offset (lk_offset)
    );

endmodule

// File: rtl/otp_dir_scanner_chk.sv
// Protocol and state checker for the OTP packet directory scanner,
// attached to every instance of the top through bind.
module otp_dir_scanner_chk #(
    parameter int MAX_PKT    = 64,
    parameter int AW         = 16,
    parameter int SW         = 16,
    parameter int SIZE_LIMIT = 11264,
    localparam int IDW       = $clog2(MAX_PKT),
    localparam int CW        = $clog2(MAX_PKT + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           rom_rd,
    input logic [AW-1:0]  rom_addr,
    input logic [31:0]    rom_data,
    input logic [IDW-1:0] lk_id,
    input logic           lk_valid,
    input logic [AW-1:0]  lk_offset,
    input logic [CW-1:0]  pkt_count,
    input logic [SW-1:0]  total_bytes,
    input logic           done,
    input logic           overflow
);

    logic unused_chk;
    assign unused_chk = ^rom_data;

    assert_first_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd && pkt_count == '0) |-> rom_addr == '0);

    assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd && !start) |=> !rom_rd);

    assert_no_read_when_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |-> !done);

    assert_count_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (pkt_count == $past(pkt_count) || pkt_count == $past(pkt_count) + 1'b1));

    assert_total_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> total_bytes >= $past(total_bytes));

    assert_limit_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |-> total_bytes < SW'(SIZE_LIMIT));

    assert_ovf_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (done && pkt_count == CW'(MAX_PKT)));

    assert_count_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_count <= CW'(MAX_PKT));

    assert_lookup_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> CW'(lk_id) < pkt_count);

    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> lk_offset == '0);

    assert_busy_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !lk_valid);

    assert_start_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (pkt_count == '0 && total_bytes == '0 && !done && !overflow));

    assert_done_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pkt_count) && $stable(total_bytes)));

endmodule

bind otp_dir_scanner otp_dir_scanner_chk #(
    .MAX_PKT(MAX_PKT), .AW(AW), .SW(SW), .SIZE_LIMIT(SIZE_LIMIT)
) u_chk (.*);

// File: tb/otp_dir_scanner_test.sv
module otp_dir_scanner_test;

    localparam int MAXP  = 64;
    localparam int LIMIT = 11264;
    localparam int MEMW  = 4096;
    localparam int NVEC  = 8;
    // Vector fields: [23:16] payload length S, [15:8] packets written, [7:0] packets expected
    localparam logic [23:0] VEC [NVEC] = '{
        {8'd1,   8'd3,  8'd3},
        {8'd255, 8'd2,  8'd2},
        {8'd5,   8'd0,  8'd0},
        {8'd200, 8'd10, 8'd10},
        {8'd255, 8'd20, 8'd11},
        {8'd254, 8'd20, 8'd12},
        {8'd1,   8'd70, 8'd64},
        {8'd1,   8'd64, 8'd64}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rom_rd;
    logic [15:0] rom_addr;
    logic [31:0] rom_data = '0;
    logic [5:0]  lk_id = '0;
    logic        lk_valid;
    logic [15:0] lk_offset;
    logic [6:0]  pkt_count;
    logic [15:0] total_bytes;
    logic        done;
    logic        overflow;

    logic [31:0] mem [MEMW];
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    otp_dir_scanner uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rom_rd(rom_rd),
        .rom_addr(rom_addr), .rom_data(rom_data), .lk_id(lk_id),
        .lk_valid(lk_valid), .lk_offset(lk_offset), .pkt_count(pkt_count),
        .total_bytes(total_bytes), .done(done), .overflow(overflow)
    );

    // Memory model: one cycle of read latency
    always @(posedge clk) begin
        if (rom_rd) rom_data <= mem[rom_addr[11:0]];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Lay out n packets of length S, payload noise, then a zero-length header
    task automatic fill(input int s, input int n);
        for (int i = 0; i < MEMW; i++) mem[i] = 32'h1234_5678;
        for (int k = 0; k < n; k++) mem[k*(s+2)] = {16'hA5C3, 8'(s), 8'h3C};
        if (n*(s+2) < MEMW) mem[n*(s+2)] = 32'hFFFF_00FF;
    endtask

    task automatic pulse_start;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done, req, 0, 1);
    endtask

    task automatic check_dir(input int s, input int c, input bit ovf, input string req);
        chk(pkt_count == 7'(c), {req, " count"}, pkt_count, c);
        chk(total_bytes == 16'(c*4*(s+1)), {req, " total R6"}, total_bytes, c*4*(s+1));
        chk(overflow == ovf, {req, " overflow R8"}, overflow, ovf);
        for (int k = 0; k < c; k++) begin
            lk_id = 6'(k);
            #1;
            chk(lk_valid && lk_offset == 16'(k*(s+2)), {req, " offset R5 R9"}, lk_offset, k*(s+2));
        end
        if (c < MAXP) begin
            lk_id = 6'(c);
            #1;
            chk(!lk_valid && lk_offset == 16'd0, {req, " id>=count R9"}, lk_valid, 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R12: reset state, then automatic walk after release (R1)
        fill(3, 4);
        repeat (3) @(negedge clk);
        chk(pkt_count == 0 && total_bytes == 0, "R12 reset count/total", pkt_count, 0);
        chk(!done && !overflow, "R12 reset done/overflow", done, 0);
        rst_n = 1'b1;
        wait_done("R1 auto walk after reset");
        check_dir(3, 4, 1'b0, "R1");

        // Table of uniform layouts (R3 R4 R5 R6 R7 R8)
        for (int v = 0; v < NVEC; v++) begin
            int s = int'(VEC[v][23:16]);
            int n = int'(VEC[v][15:8]);
            int c = int'(VEC[v][7:0]);
            fill(s, n);
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            chk(rom_rd && rom_addr == 16'd0, "R2 first read at word 0", rom_addr, 0);
            chk(!done && !lk_valid, "R10 busy lookup invalid", lk_valid, 0);
            @(negedge clk);
            chk(!rom_rd, "R2 single outstanding read", rom_rd, 0);
            wait_done("R4 walk ends");
            check_dir(s, c, n > MAXP, "R3 R4 R7 vector");
        end

        // R11: restart in mid-walk onto a new layout
        fill(1, 70);
        pulse_start();
        repeat (20) @(negedge clk);
        chk(!done && pkt_count != 0, "R11 walk in progress", pkt_count, 1);
        fill(2, 5);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(pkt_count == 0 && total_bytes == 0 && !done, "R11 start clears", pkt_count, 0);
        wait_done("R11 restarted walk");
        check_dir(2, 5, 1'b0, "R11");

        // R12: reset in mid-walk clears state
        fill(1, 70);
        pulse_start();
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(pkt_count == 0 && !done && !overflow && total_bytes == 0, "R12 mid-walk reset", pkt_count, 0);
        rst_n = 1'b1;
        wait_done("R12 walk after reset");
        check_dir(1, 64, 1'b1, "R12 R8");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule